// File: doc/BRIEF.md
# Programmable Asynchronous Serial Receiver

This block takes one asynchronous serial line and turns it into characters for a host-side read port. The frame has a low start bit and then 5 to 8 data bits, least significant first. An optional parity bit may follow, and the frame closes with a stop bit. The host picks the character length and the parity rule on configuration inputs. Sampling follows an external rate enable, `rateTick`. That enable is either a 16x oversampling strobe or, when `cfgOneX` is high, a bit clock that already lands in the middle of each bit. Generating the baud rate is left to the surrounding logic.

Finished characters go into a four-entry holding buffer. Each entry carries its own parity-error and framing-error tags, and the oldest entry is always shown on the read port. The block flags overrun when a character arrives while the buffer is full. It also tracks a line break: a one-cycle event marks its start, another marks its end, and a level is held between them. A break is found even when the line drops partway through a character. A flow-control output tells the remote transmitter to pause whenever the buffer is full.

Top module: `async_rx_core`

## Requirements
- R1: `cfgDataLen` selects the character length: 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits. Bits arrive least significant first after a low start bit. The received value sits right-aligned on `rdData`, and the unused upper bits read 0.
- R2: `cfgParity` sets the parity rule: 0 means no parity bit, 1 even, 2 odd, and 3 forced to the level on `cfgParLvl`. A parity bit that breaks the rule sets `rdParErr` for that character only.
- R3: With `cfgOneX`=0, a low line seen on a tick starts a frame. The start bit is confirmed 8 ticks later, and every later bit is sampled 16 ticks after the one before it. With `cfgOneX`=1, the line is sampled on every tick.
- R4: In 16x mode, a start edge whose line is back high at the mid-start sample is dropped. Nothing is stored, and the next real frame is received normally.
- R5: A stop bit sampled low sets `rdFrmErr` for that character. The character is still stored.
- R6: The buffer holds 4 characters in arrival order. The oldest is shown on `rdData`/`rdParErr`/`rdFrmErr`, and `rdData` reads 0 when the buffer is empty. A high `rdEn` removes the oldest entry. `rxReady` is high while at least one entry is held, and `rxFull` is high at 4 entries.
- R7: A character that completes while the buffer is full is discarded. This happens even if `rdEn` is high in the same cycle. `overrun` is then set and stays set until `ovrClr`; if both happen in one cycle, setting wins.
- R8: `flowGo` is low exactly while the buffer is full and high otherwise.
- R9: A break starts once the line has been low at a whole frame's worth of consecutive sample points. That count is 2 + data bits + 1 when parity is enabled. The run may begin mid-character. A break start gives one cycle of `breakStart`, and `breakActive` then stays high. The character with the low stop bit is stored once.
- R10: While `breakActive` is high, the first sample point that finds the line high gives one cycle of `breakEnd`. It also clears `breakActive` and returns the receiver to idle, ready for a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rateTick | input | 1 | Sampling enable, 16x or 1x per `cfgOneX` |
| cfgOneX | input | 1 | 1: tick is a mid-bit clock; 0: 16x oversampling |
| cfgDataLen | input | 2 | Character length code (5 + value bits) |
| cfgParity | input | 2 | Parity rule: none, even, odd, forced |
| cfgParLvl | input | 1 | Expected parity level in forced mode |
| rxLine | input | 1 | Serial input, idle high |
| rdEn | input | 1 | Remove the oldest buffered character |
| ovrClr | input | 1 | Clear the overrun flag |
| rdData | output | 8 | Oldest character, right-aligned |
| rdParErr | output | 1 | Parity error tag of the oldest character |
| rdFrmErr | output | 1 | Framing error tag of the oldest character |
| rxReady | output | 1 | Buffer holds at least one character |
| rxFull | output | 1 | Buffer holds four characters |
| overrun | output | 1 | A character was lost to a full buffer |
| flowGo | output | 1 | High when the remote side may keep sending |
| breakStart | output | 1 | One-cycle event at the start of a break |
| breakEnd | output | 1 | One-cycle event at the end of a break |
| breakActive | output | 1 | Break in progress |

## Verification
The line passes through a two-flop synchroniser, so a level change reaches the sampler two clock edges after it is driven. The bench always drives the line several clocks before the next tick. A character is written into the buffer at the clock edge of its stop-bit sample point. In 16x mode that edge falls at tick 8 of the stop bit. The bench checks the buffer only after the rest of the stop bit and one full idle bit have been sent. Break start and end are single-cycle events, so the bench counts them on every clock edge. It compares those counts, and the `breakActive` level, at bit boundaries that lie at least one whole bit period after the sample point where each event is due.

// File: rtl/rxcfg_pkg.sv
package rxcfg_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_FORCE = 2'd3
  } parMode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_LOW
  } rxState_t;

  // Strobes from the sequencer into the datapath
  typedef struct packed {
    logic startOk;    // start bit confirmed, clear the assembly state
    logic shiftEn;    // data bit sampled
    logic parEn;      // parity bit sampled
    logic frameDone;  // stop bit sampled
    logic bitVal;     // the synchronised line level at this sample point
  } rxStrobe_t;

endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rxcfg_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rateTick,
  input  logic       cfgOneX,
  input  logic [1:0] cfgDataLen,
  input  logic [1:0] cfgParity,
  input  logic       rxLine,
  output rxStrobe_t  strobe,
  output logic       breakStart,
  output logic       breakEnd,
  output logic       breakActive
);

  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] HALF = PH_W'(OVS / 2 - 1);
  localparam logic [PH_W-1:0] LAST = PH_W'(OVS - 1);

  logic [1:0]     syncQ;
  logic           lineS;
  rxState_t       state;
  logic [PH_W-1:0] phase;
  logic [2:0]     bitCnt;
  logic [3:0]     lowRun;
  logic           brkAct;
  logic           sampleNow;
  logic           parOn;
  logic [3:0]     frameBits;
  logic [2:0]     lastData;
  logic [3:0]     lowRunInc;

  assign lineS     = syncQ[1];
  assign parOn     = (cfgParity != 2'(PAR_NONE));
  assign frameBits = 4'd7 + {2'b00, cfgDataLen} + {3'b000, parOn};
  assign lastData  = 3'd4 + {1'b0, cfgDataLen};
  assign lowRunInc = lowRun + 4'd1;

  always_comb begin
    if (cfgOneX) begin
      sampleNow = rateTick;
    end else begin
      case (state)
        ST_IDLE:  sampleNow = 1'b0;
        ST_START: sampleNow = rateTick && (phase == HALF);
        default:  sampleNow = rateTick && (phase == LAST);
      endcase
    end
  end

  always_comb begin
    strobe.bitVal    = lineS;
    strobe.startOk   = sampleNow && !lineS &&
                       ((state == ST_START) || (state == ST_IDLE && cfgOneX));
    strobe.shiftEn   = sampleNow && (state == ST_DATA);
    strobe.parEn     = sampleNow && (state == ST_PAR);
    strobe.frameDone = sampleNow && (state == ST_STOP);
  end

  assign breakStart  = sampleNow && !lineS && !brkAct && (lowRunInc == frameBits);
  assign breakEnd    = sampleNow && lineS && brkAct;
  assign breakActive = brkAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      state  <= ST_IDLE;
      phase  <= '0;
      bitCnt <= '0;
      lowRun <= '0;
      brkAct <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rxLine};

      // oversampling phase
      if (!cfgOneX && rateTick) begin
        if (state == ST_IDLE) begin
          phase <= '0;
        end else if (state == ST_START && phase == HALF) begin
          phase <= '0;
        end else begin
          phase <= phase + 1'b1;
        end
      end

      // run of consecutive low sample points
      if (sampleNow) begin
        if (lineS) begin
          lowRun <= '0;
        end else if (lowRun != 4'hF) begin
          lowRun <= lowRunInc;
        end
      end

      if (breakStart) begin
        brkAct <= 1'b1;
      end else if (breakEnd) begin
        brkAct <= 1'b0;
      end

      case (state)
        ST_IDLE: begin
          if (rateTick && !lineS) begin
            state  <= cfgOneX ? ST_DATA : ST_START;
            bitCnt <= '0;
          end
        end
        ST_START: begin
          if (sampleNow) begin
            state <= lineS ? ST_IDLE : ST_DATA;
          end
        end
        ST_DATA: begin
          if (sampleNow) begin
            if (bitCnt == lastData) begin
              state <= parOn ? ST_PAR : ST_STOP;
            end else begin
              bitCnt <= bitCnt + 3'd1;
            end
          end
        end
        ST_PAR: begin
          if (sampleNow) begin
            state <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (sampleNow) begin
            state <= lineS ? ST_IDLE : ST_LOW;
          end
        end
        default: begin
          if (sampleNow && lineS) begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/rx_data.sv
module rx_data
  import rxcfg_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic [1:0]        cfgDataLen,
  input  logic [1:0]        cfgParity,
  input  logic              cfgParLvl,
  input  logic              rdEn,
  input  logic              ovrClr,
  output logic [CHAR_W-1:0] rdData,
  output logic              rdParErr,
  output logic              rdFrmErr,
  output logic              rxReady,
  output logic              rxFull,
  output logic              overrun,
  output logic              flowGo
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int ENT_W = CHAR_W + 2;

  logic [CHAR_W-1:0] shiftReg;
  logic              parAcc;
  logic              parErrQ;
  logic              parErrNow;
  logic [CHAR_W-1:0] aligned;
  logic [ENT_W-1:0]  mem [DEPTH];
  logic [ENT_W-1:0]  head;
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W:0]    count;
  logic              empty;
  logic              doPush;
  logic              doPop;
  logic              ovrQ;

  assign aligned = shiftReg >> (2'd3 - cfgDataLen);

  always_comb begin
    case (parMode_t'(cfgParity))
      PAR_EVEN:  parErrNow = parAcc ^ strobe.bitVal;
      PAR_ODD:   parErrNow = ~(parAcc ^ strobe.bitVal);
      PAR_FORCE: parErrNow = strobe.bitVal ^ cfgParLvl;
      default:   parErrNow = 1'b0;
    endcase
  end

  // character assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parErrQ  <= 1'b0;
    end else if (strobe.startOk) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parErrQ  <= 1'b0;
    end else if (strobe.shiftEn) begin
      shiftReg <= {strobe.bitVal, shiftReg[CHAR_W-1:1]};
      parAcc   <= parAcc ^ strobe.bitVal;
    end else if (strobe.parEn) begin
      parErrQ  <= parErrNow;
    end
  end

  // holding buffer
  assign empty  = (count == '0);
  assign rxFull = (count == (PTR_W + 1)'(DEPTH));
  assign doPush = strobe.frameDone && !rxFull;
  assign doPop  = rdEn && !empty;

  always_ff @(posedge clk) begin
    if (doPush) begin
      mem[wrPtr] <= {~strobe.bitVal, parErrQ, aligned};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      ovrQ  <= 1'b0;
    end else begin
      if (doPush) begin
        wrPtr <= wrPtr + 1'b1;
      end
      if (doPop) begin
        rdPtr <= rdPtr + 1'b1;
      end
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strobe.frameDone && rxFull) begin
        ovrQ <= 1'b1;
      end else if (ovrClr) begin
        ovrQ <= 1'b0;
      end
    end
  end

  assign head     = empty ? '0 : mem[rdPtr];
  assign rdData   = head[CHAR_W-1:0];
  assign rdParErr = head[CHAR_W];
  assign rdFrmErr = head[CHAR_W+1];
  assign rxReady  = !empty;
  assign overrun  = ovrQ;
  assign flowGo   = !rxFull;

endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
  import rxcfg_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rateTick,
  input  logic       cfgOneX,
  input  logic [1:0] cfgDataLen,
  input  logic [1:0] cfgParity,
  input  logic       cfgParLvl,
  input  logic       rxLine,
  input  logic       rdEn,
  input  logic       ovrClr,
  output logic [7:0] rdData,
  output logic       rdParErr,
  output logic       rdFrmErr,
  output logic       rxReady,
  output logic       rxFull,
  output logic       overrun,
  output logic       flowGo,
  output logic       breakStart,
  output logic       breakEnd,
  output logic       breakActive
);

  rxStrobe_t strobe;

  rx_ctrl #(.OVS(OVS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rateTick    (rateTick),
    .cfgOneX     (cfgOneX),
    .cfgDataLen  (cfgDataLen),
    .cfgParity   (cfgParity),
    .rxLine      (rxLine),
    .strobe      (strobe),
    .breakStart  (breakStart),
    .breakEnd    (breakEnd),
    .breakActive (breakActive)
  );

  rx_data #(.DEPTH(DEPTH)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgDataLen (cfgDataLen),
    .cfgParity  (cfgParity),
    .cfgParLvl  (cfgParLvl),
    .rdEn       (rdEn),
    .ovrClr     (ovrClr),
    .rdData     (rdData),
    .rdParErr   (rdParErr),
    .rdFrmErr   (rdFrmErr),
    .rxReady    (rxReady),
    .rxFull     (rxFull),
    .overrun    (overrun),
    .flowGo     (flowGo)
  );

endmodule

// File: rtl/rx_checker.sv
module rx_checker (
  input logic clk,
  input logic rstN,
  input logic rdEn,
  input logic ovrClr,
  input logic rxReady,
  input logic rxFull,
  input logic overrun,
  input logic flowGo,
  input logic breakStart,
  input logic breakEnd,
  input logic breakActive
);

  AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rxFull |-> rxReady); // R6
  AST_POP_MAKES_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rxReady) |=> !rxFull); // R6
  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !rdEn) |=> rxFull); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !ovrClr) |=> overrun); // R7
  AST_FLOW_OPEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !rxReady |-> flowGo); // R8
  AST_BRK_START_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    breakStart |=> breakActive); // R9
  AST_BRK_START_FRESH: assert property (@(posedge clk) disable iff (!rstN)
    breakStart |-> !breakActive); // R9
  AST_BRK_END_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    breakEnd |=> !breakActive); // R10
  AST_BRK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({breakStart, breakEnd})); // R10

endmodule

bind async_rx_core rx_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .rdEn        (rdEn),
  .ovrClr      (ovrClr),
  .rxReady     (rxReady),
  .rxFull      (rxFull),
  .overrun     (overrun),
  .flowGo      (flowGo),
  .breakStart  (breakStart),
  .breakEnd    (breakEnd),
  .breakActive (breakActive)
);

// File: tb/tb_async_rx_core.sv
module tb_async_rx_core;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rateTick = 1'b0;
  logic       cfgOneX = 1'b0;
  logic [1:0] cfgDataLen = 2'd3;
  logic [1:0] cfgParity = 2'd0;
  logic       cfgParLvl = 1'b0;
  logic       rxLine = 1'b1;
  logic       rdEn = 1'b0;
  logic       ovrClr = 1'b0;
  logic [7:0] rdData;
  logic       rdParErr, rdFrmErr, rxReady, rxFull, overrun, flowGo;
  logic       breakStart, breakEnd, breakActive;

  int nChecks = 0;
  int nFails = 0;
  int nBrkStart = 0;
  int nBrkEnd = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  async_rx_core dut (
    .clk(clk), .rstN(rstN), .rateTick(rateTick), .cfgOneX(cfgOneX),
    .cfgDataLen(cfgDataLen), .cfgParity(cfgParity), .cfgParLvl(cfgParLvl),
    .rxLine(rxLine), .rdEn(rdEn), .ovrClr(ovrClr), .rdData(rdData),
    .rdParErr(rdParErr), .rdFrmErr(rdFrmErr), .rxReady(rxReady),
    .rxFull(rxFull), .overrun(overrun), .flowGo(flowGo),
    .breakStart(breakStart), .breakEnd(breakEnd), .breakActive(breakActive)
  );

  always @(posedge clk) begin
    if (rstN) begin
      if (breakStart) nBrkStart++;
      if (breakEnd) nBrkEnd++;
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tickPulse();
    repeat (3) @(negedge clk);
    rateTick = 1'b1;
    @(negedge clk);
    rateTick = 1'b0;
  endtask

  task automatic sendBit(input logic v);
    rxLine = v;
    if (cfgOneX) tickPulse();
    else repeat (16) tickPulse();
  endtask

  function automatic logic parOf(input logic [7:0] d, input logic corrupt);
    logic x = 1'b0;
    logic p;
    for (int i = 0; i < int'(cfgDataLen) + 5; i++) x ^= d[i];
    case (cfgParity)
      2'd1:    p = x;
      2'd2:    p = ~x;
      default: p = cfgParLvl;
    endcase
    return p ^ corrupt;
  endfunction

  task automatic sendFrame(input logic [7:0] d, input logic corrupt, input logic stopV);
    sendBit(1'b0);
    for (int i = 0; i < int'(cfgDataLen) + 5; i++) sendBit(d[i]);
    if (cfgParity != 2'd0) sendBit(parOf(d, corrupt));
    sendBit(stopV);
    sendBit(1'b1);
  endtask

  task automatic popOne();
    @(negedge clk);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic expectHead(input string req, input logic [7:0] d, input logic pe, input logic fe);
    chk({req, " data"}, rdData, d);
    chk({req, " parity tag"}, rdParErr, pe);
    chk({req, " framing tag"}, rdFrmErr, fe);
    popOne();
  endtask

  task automatic t_reset();
    chk("R6 reset ready", rxReady, 0);
    chk("R6 reset full", rxFull, 0);
    chk("R6 reset data", rdData, 0);
    chk("R7 reset overrun", overrun, 0);
    chk("R8 reset flow", flowGo, 1);
    chk("R9 reset break", breakActive, 0);
  endtask

  task automatic t_len8();
    cfgOneX = 0; cfgDataLen = 3; cfgParity = 0;
    sendFrame(8'hA5, 0, 1);
    chk("R6 ready after one char", rxReady, 1);
    expectHead("R1 8N 0xA5", 8'hA5, 0, 0);
    chk("R6 empty after pop", rxReady, 0);
  endtask

  task automatic t_len5Even();
    cfgDataLen = 0; cfgParity = 1;
    sendFrame(8'h13, 0, 1);
    expectHead("R1 5E good", 8'h13, 0, 0);
    sendFrame(8'h13, 1, 1);
    expectHead("R2 5E bad parity", 8'h13, 1, 0);
  endtask

  task automatic t_oddForced();
    cfgDataLen = 2; cfgParity = 2;
    sendFrame(8'h5A, 0, 1);
    expectHead("R2 7O good", 8'h5A, 0, 0);
    sendFrame(8'h5A, 1, 1);
    expectHead("R2 7O bad", 8'h5A, 1, 0);
    cfgDataLen = 1; cfgParity = 3; cfgParLvl = 1;
    sendFrame(8'h2B, 0, 1);
    expectHead("R2 6 forced-1 good", 8'h2B, 0, 0);
    sendFrame(8'h2B, 1, 1);
    expectHead("R2 6 forced-1 bad", 8'h2B, 1, 0);
  endtask

  task automatic t_oneX();
    cfgOneX = 1; cfgDataLen = 3; cfgParity = 0;
    repeat (2) sendBit(1'b1);
    sendFrame(8'h3C, 0, 1);
    expectHead("R3 1x char", 8'h3C, 0, 0);
    sendFrame(8'hC1, 0, 1);
    expectHead("R3 1x second char", 8'hC1, 0, 0);
    cfgOneX = 0;
    repeat (2) sendBit(1'b1);
  endtask

  task automatic t_falseStart();
    cfgDataLen = 3; cfgParity = 0;
    rxLine = 1'b0;
    repeat (4) tickPulse();
    rxLine = 1'b1;
    repeat (28) tickPulse();
    chk("R4 glitch not stored", rxReady, 0);
    sendFrame(8'h69, 0, 1);
    expectHead("R4 char after glitch", 8'h69, 0, 0);
  endtask

  task automatic t_frame();
    sendFrame(8'hFF, 0, 0);
    expectHead("R5 low stop", 8'hFF, 0, 1);
    chk("R5 no break from short low", nBrkStart, 0);
  endtask

  task automatic t_fifo();
    cfgDataLen = 3; cfgParity = 0;
    sendFrame(8'h11, 0, 1);
    sendFrame(8'h22, 0, 1);
    sendFrame(8'h33, 0, 1);
    chk("R8 flow open at three", flowGo, 1);
    sendFrame(8'h44, 0, 1);
    chk("R6 full at four", rxFull, 1);
    chk("R8 flow closed at four", flowGo, 0);
    chk("R7 no overrun yet", overrun, 0);
    sendFrame(8'h55, 0, 1);
    chk("R7 overrun set", overrun, 1);
    expectHead("R6 order 1", 8'h11, 0, 0);
    chk("R8 flow reopened", flowGo, 1);
    expectHead("R6 order 2", 8'h22, 0, 0);
    expectHead("R6 order 3", 8'h33, 0, 0);
    expectHead("R7 last kept is 4th", 8'h44, 0, 0);
    chk("R7 fifth discarded", rxReady, 0);
    chk("R7 overrun sticky", overrun, 1);
    @(negedge clk); ovrClr = 1; @(negedge clk); ovrClr = 0;
    chk("R7 overrun cleared", overrun, 0);
  endtask

  task automatic t_breakWhole();
    int s0 = nBrkStart;
    int e0 = nBrkEnd;
    repeat (12) sendBit(1'b0);
    chk("R9 break active", breakActive, 1);
    chk("R9 one start event", nBrkStart - s0, 1);
    repeat (2) sendBit(1'b1);
    chk("R10 break ended", breakActive, 0);
    chk("R10 one end event", nBrkEnd - e0, 1);
    expectHead("R9 zero char stored", 8'h00, 0, 1);
    chk("R9 only one char", rxReady, 0);
  endtask

  task automatic t_breakMid();
    int s0 = nBrkStart;
    int e0 = nBrkEnd;
    sendBit(1'b0);
    repeat (3) sendBit(1'b1);
    repeat (9) sendBit(1'b0);
    chk("R9 mid-char not yet", breakActive, 0);
    repeat (3) sendBit(1'b0);
    chk("R9 mid-char break active", breakActive, 1);
    chk("R9 mid-char start event", nBrkStart - s0, 1);
    repeat (2) sendBit(1'b1);
    chk("R10 mid-char end event", nBrkEnd - e0, 1);
    expectHead("R9 partial char", 8'h07, 0, 1);
    sendFrame(8'h81, 0, 1);
    expectHead("R10 receives after break", 8'h81, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    repeat (2) sendBit(1'b1);
    t_len8();
    t_len5Even();
    t_oddForced();
    t_oneX();
    t_falseStart();
    t_frame();
    t_fifo();
    t_breakWhole();
    t_breakMid();
    finishRun();
  end

endmodule